// File: doc/BRIEF.md
# Interrupt Entry Microsequencer

This block takes over the processor's fetch path when an exception must be entered. Three sources can cause an entry: eight prioritized interrupt request lines, a falling edge on the active-low non-maskable interrupt line, and the execution of a breakpoint instruction. Each source is first captured in a pending latch. At the next instruction boundary the block picks the winning source and freezes a cause word that software can read. It then drives a fixed five-cycle microsequence. Four cycles push the flags, B, PC and A registers, each with a stack-pointer pre-decrement. The fifth cycle loads the program counter from the single shared vector address. The interrupt-enable flag is cleared only after the flags word has been pushed.

The register file, stack memory and flags register are outside this block. It only emits strobes and selects toward them, and it receives the current interrupt-enable bit as an input. Maskable requests that arrive while the enable is low stay latched. They are taken at the first boundary after software reloads the flags with the enable set.

States: `ST_IDLE` (waiting for a boundary), `ST_PUSH_FLG`, `ST_PUSH_B`, `ST_PUSH_PC`, `ST_PUSH_A`, `ST_VECTOR`.

Transitions:
- IDLE→PUSH_FLG happens on an instruction boundary with an eligible pending source. Otherwise the block stays in IDLE.
- PUSH_FLG→PUSH_B, PUSH_B→PUSH_PC, PUSH_PC→PUSH_A and PUSH_A→VECTOR are unconditional.
- VECTOR→IDLE is unconditional.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset, `busy`, `push_req`, `sp_dec`, `ie_clr` and `pc_load` are 0 and `cause_word` is 0.
- R2: An entry starts in the cycle after an accepted boundary and lasts five cycles.
  - Cycles 1 to 4 assert `push_req` with `push_sel` equal to 0 (flags), 1 (B), 2 (PC) and 3 (A), in that order.
  - Cycle 5 asserts `pc_load` with `vec_addr` = 16'hFFFF and no push.
  - `busy` is high exactly during these five cycles.
- R3: `sp_dec` is asserted in every push cycle and in no other cycle. The stack write uses the decremented pointer.
- R4: `ie_clr` is a single-cycle strobe in the B push cycle, which is the cycle after the flags push.
- R5: A pulse on `irq_req[i]` is latched. A boundary with `irq_en`=0 does not take it. The first boundary with `irq_en`=1 takes it, and taking it clears only that latch.
- R6: Among pending IRQs, the lowest index is taken first. The others remain pending for later boundaries.
- R7: A falling edge on `nmi_n` is latched and taken at the next boundary regardless of `irq_en`. Holding `nmi_n` low produces only one entry.
- R8: If more than one source is pending at a boundary, the NMI wins over the breakpoint, and the breakpoint wins over an IRQ. The losing sources stay pending.
- R9: `cause_word` is loaded at the start of an entry and held until the next entry. Its fields are:
  - bits [2:0]: IRQ level
  - bit 3: IRQ taken
  - bit 4: NMI taken
  - bit 5: breakpoint taken
  - At most one of bits 5:3 is set.
- R10: `insn_bound` has no effect while `busy` is high. A boundary held high through an entry does not lengthen or restart it.
- R11: A `brk_exec` pulse is latched and taken at the next boundary regardless of `irq_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 8 | Interrupt request lines; index 0 has the highest priority |
| nmi_n | input | 1 | Active-low non-maskable interrupt; acts on its falling edge |
| brk_exec | input | 1 | One-cycle pulse when a breakpoint instruction executes |
| irq_en | input | 1 | Current interrupt-enable flag |
| insn_bound | input | 1 | Instruction boundary at which an entry may begin |
| busy | output | 1 | High while the sequence owns the fetch path |
| push_req | output | 1 | Stack push strobe |
| push_sel | output | 2 | Register to push: 0 flags, 1 B, 2 PC, 3 A |
| sp_dec | output | 1 | Stack pointer pre-decrement strobe |
| ie_clr | output | 1 | Clear the interrupt-enable flag |
| pc_load | output | 1 | Load PC from `vec_addr` |
| vec_addr | output | 16 | Shared entry vector address |
| cause_word | output | 6 | Cause of the last entry |

## Verification
Several sources can become pending together and meet the same boundary, so arbitration and latching are the central concern. The bench posts an NMI edge and an IRQ in the same cycle, and separately a breakpoint and an IRQ in the same cycle. For each pair it checks that the cause word names only the winner. It then raises the enable and pulses further boundaries, and checks that the loser is taken afterwards. A second overlap is a boundary that stays high through an entry while another IRQ is pending. Here the bench checks that the vector cycle still ends the entry on time, and that the next entry starts only after an idle cycle.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_PUSH_FLG = 3'd1,
        ST_PUSH_B   = 3'd2,
        ST_PUSH_PC  = 3'd3,
        ST_PUSH_A   = 3'd4,
        ST_VECTOR   = 3'd5
    } seq_state_t;

    typedef enum logic [1:0] {
        SEL_FLAGS = 2'd0,
        SEL_B     = 2'd1,
        SEL_PC    = 2'd2,
        SEL_A     = 2'd3
    } push_sel_t;

endpackage

// File: rtl/nmi_edge_det.sv
module nmi_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_n,
    input  logic take,
    output logic pend
);
    logic prev_q;
    logic pend_q;
    logic fall;

    // Line idles high; a high-to-low transition is the event.
    assign fall = prev_q & ~nmi_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b1;
            pend_q <= 1'b0;
        end else begin
            prev_q <= nmi_n;
            pend_q <= (pend_q & ~take) | fall;
        end
    end

    assign pend = pend_q;
endmodule

// File: rtl/irq_prio_latch.sv
module irq_prio_latch #(
    parameter int NUM_IRQ = 8,
    localparam int LVL_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] irq_req,
    input  logic               take,
    output logic               any,
    output logic [LVL_W-1:0]   level
);
    logic [NUM_IRQ-1:0] pend_q;
    logic [NUM_IRQ-1:0] clr_mask;
    logic [LVL_W-1:0]   lvl_c;

    // Lowest index wins: scan downward so the last hit is the smallest.
    always_comb begin
        lvl_c = '0;
        for (int i = NUM_IRQ - 1; i >= 0; i--) begin
            if (pend_q[i]) lvl_c = LVL_W'(i);
        end
    end

    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_clr
        assign clr_mask[g] = take && (lvl_c == LVL_W'(g));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr_mask) | irq_req;
    end

    assign any   = |pend_q;
    assign level = lvl_c;
endmodule

// File: rtl/entry_fsm.sv
module entry_fsm
    import irq_entry_pkg::*;
#(
    parameter int          LVL_W    = 3,
    parameter int          ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] VEC_ADDR = '1,
    localparam int         CAUSE_W  = LVL_W + 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               insn_bound,
    input  logic               irq_en,
    input  logic               nmi_pend,
    input  logic               brk_pend,
    input  logic               irq_any,
    input  logic [LVL_W-1:0]   irq_level,
    output logic               take_nmi,
    output logic               take_brk,
    output logic               take_irq,
    output logic               busy,
    output logic               push_req,
    output logic [1:0]         push_sel,
    output logic               sp_dec,
    output logic               ie_clr,
    output logic               pc_load,
    output logic [ADDR_W-1:0]  vec_addr,
    output logic [CAUSE_W-1:0] cause
);
    seq_state_t state_q, state_n;
    logic [CAUSE_W-1:0] cause_q;
    logic start;

    assign start    = (state_q == ST_IDLE) && insn_bound;
    assign take_nmi = start && nmi_pend;
    assign take_brk = start && !nmi_pend && brk_pend;
    assign take_irq = start && !nmi_pend && !brk_pend && irq_en && irq_any;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cause_q <= '0;
        end else begin
            state_q <= state_n;
            if (take_nmi)      cause_q <= {1'b0, 1'b1, 1'b0, {LVL_W{1'b0}}};
            else if (take_brk) cause_q <= {1'b1, 1'b0, 1'b0, {LVL_W{1'b0}}};
            else if (take_irq) cause_q <= {1'b0, 1'b0, 1'b1, irq_level};
        end
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE:     if (take_nmi || take_brk || take_irq) state_n = ST_PUSH_FLG;
            ST_PUSH_FLG: state_n = ST_PUSH_B;
            ST_PUSH_B:   state_n = ST_PUSH_PC;
            ST_PUSH_PC:  state_n = ST_PUSH_A;
            ST_PUSH_A:   state_n = ST_VECTOR;
            ST_VECTOR:   state_n = ST_IDLE;
            default:     state_n = ST_IDLE;
        endcase
    end

    always_comb begin
        busy     = 1'b1;
        push_req = 1'b0;
        push_sel = SEL_FLAGS;
        sp_dec   = 1'b0;
        ie_clr   = 1'b0;
        pc_load  = 1'b0;
        unique case (state_q)
            ST_IDLE:     busy = 1'b0;
            ST_PUSH_FLG: begin push_req = 1'b1; sp_dec = 1'b1; push_sel = SEL_FLAGS; end
            ST_PUSH_B:   begin push_req = 1'b1; sp_dec = 1'b1; push_sel = SEL_B; ie_clr = 1'b1; end
            ST_PUSH_PC:  begin push_req = 1'b1; sp_dec = 1'b1; push_sel = SEL_PC; end
            ST_PUSH_A:   begin push_req = 1'b1; sp_dec = 1'b1; push_sel = SEL_A; end
            ST_VECTOR:   pc_load = 1'b1;
            default:     busy = 1'b0;
        endcase
    end

    assign vec_addr = VEC_ADDR;
    assign cause    = cause_q;
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
    parameter int                NUM_IRQ  = 8,
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] VEC_ADDR = 16'hFFFF,
    localparam int               LVL_W    = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1,
    localparam int               CAUSE_W  = LVL_W + 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] irq_req,
    input  logic               nmi_n,
    input  logic               brk_exec,
    input  logic               irq_en,
    input  logic               insn_bound,
    output logic               busy,
    output logic               push_req,
    output logic [1:0]         push_sel,
    output logic               sp_dec,
    output logic               ie_clr,
    output logic               pc_load,
    output logic [ADDR_W-1:0]  vec_addr,
    output logic [CAUSE_W-1:0] cause_word
);
    logic             nmi_pend, brk_q, irq_any;
    logic [LVL_W-1:0] irq_level;
    logic             take_nmi, take_brk, take_irq;

    nmi_edge_det u_nmi (
        .clk   (clk),
        .rst_n (rst_n),
        .nmi_n (nmi_n),
        .take  (take_nmi),
        .pend  (nmi_pend)
    );

    irq_prio_latch #(.NUM_IRQ(NUM_IRQ)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .irq_req (irq_req),
        .take    (take_irq),
        .any     (irq_any),
        .level   (irq_level)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) brk_q <= 1'b0;
        else        brk_q <= (brk_q & ~take_brk) | brk_exec;
    end

    entry_fsm #(.LVL_W(LVL_W), .ADDR_W(ADDR_W), .VEC_ADDR(VEC_ADDR)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .insn_bound (insn_bound),
        .irq_en     (irq_en),
        .nmi_pend   (nmi_pend),
        .brk_pend   (brk_q),
        .irq_any    (irq_any),
        .irq_level  (irq_level),
        .take_nmi   (take_nmi),
        .take_brk   (take_brk),
        .take_irq   (take_irq),
        .busy       (busy),
        .push_req   (push_req),
        .push_sel   (push_sel),
        .sp_dec     (sp_dec),
        .ie_clr     (ie_clr),
        .pc_load    (pc_load),
        .vec_addr   (vec_addr),
        .cause      (cause_word)
    );
endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk #(
    parameter int ADDR_W  = 16,
    parameter int CAUSE_W = 6,
    parameter logic [ADDR_W-1:0] VEC_ADDR = 16'hFFFF
) (
    input logic               clk,
    input logic               rst_n,
    input logic               busy,
    input logic               push_req,
    input logic [1:0]         push_sel,
    input logic               sp_dec,
    input logic               ie_clr,
    input logic               pc_load,
    input logic [ADDR_W-1:0]  vec_addr,
    input logic [CAUSE_W-1:0] cause_word
);
    assert_push_has_dec_R3: assert property (@(posedge clk) disable iff (!rst_n)
        push_req |-> sp_dec);
    assert_dec_has_push_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sp_dec |-> push_req);
    assert_flags_then_b_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && push_sel == 2'd0) |=> (push_req && push_sel == 2'd1));
    assert_a_then_vector_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && push_sel == 2'd3) |=> (pc_load && !push_req && vec_addr == VEC_ADDR));
    assert_vector_ends_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |=> !busy);
    assert_start_with_flags_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (push_req && push_sel == 2'd0));
    assert_ieclr_after_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ie_clr |-> (push_req && push_sel == 2'd1 && $past(push_req && push_sel == 2'd0)));
    assert_cause_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cause_word[CAUSE_W-1 -: 3]));
    assert_cause_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !$rose(busy)) |-> $stable(cause_word));
endmodule

bind irq_entry_seq irq_entry_seq_chk #(
    .ADDR_W(ADDR_W), .CAUSE_W(CAUSE_W), .VEC_ADDR(VEC_ADDR)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .push_req   (push_req),
    .push_sel   (push_sel),
    .sp_dec     (sp_dec),
    .ie_clr     (ie_clr),
    .pc_load    (pc_load),
    .vec_addr   (vec_addr),
    .cause_word (cause_word)
);

// File: tb/irq_entry_seq_tb.sv
module irq_entry_seq_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq_req = '0;
    logic       nmi_n = 1'b1;
    logic       brk_exec = 1'b0;
    logic       irq_en = 1'b0;
    logic       insn_bound = 1'b0;
    logic       busy, push_req, sp_dec, ie_clr, pc_load;
    logic [1:0] push_sel;
    logic [15:0] vec_addr;
    logic [5:0] cause_word;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    irq_entry_seq u_dut (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .nmi_n(nmi_n),
        .brk_exec(brk_exec), .irq_en(irq_en), .insn_bound(insn_bound),
        .busy(busy), .push_req(push_req), .push_sel(push_sel), .sp_dec(sp_dec),
        .ie_clr(ie_clr), .pc_load(pc_load), .vec_addr(vec_addr),
        .cause_word(cause_word)
    );

    // {irq[7:0], nmi, brk, en, expected cause[5:0]}
    localparam int NV = 8;
    localparam logic [16:0] VTAB [NV] = '{
        {8'b0000_0100, 1'b0, 1'b0, 1'b1, 6'b001_010},
        {8'b1000_0000, 1'b0, 1'b0, 1'b1, 6'b001_111},
        {8'b0110_0000, 1'b0, 1'b0, 1'b1, 6'b001_101},
        {8'b0000_0000, 1'b1, 1'b0, 1'b0, 6'b010_000},
        {8'b0000_0000, 1'b0, 1'b1, 1'b0, 6'b100_000},
        {8'b0000_0010, 1'b1, 1'b0, 1'b1, 6'b010_000},
        {8'b0000_0001, 1'b0, 1'b1, 1'b1, 6'b100_000},
        {8'b1111_1111, 1'b0, 1'b0, 1'b1, 6'b001_000}
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Pulse a boundary and check the full five-cycle entry.
    task automatic run_entry(input logic [5:0] exp_cause, input string tag);
        @(negedge clk) insn_bound = 1'b1;
        for (int k = 1; k <= 5; k++) begin
            @(negedge clk) insn_bound = 1'b0;
            chk(busy == 1'b1, {tag, " R2 busy"}, busy, 1);
            if (k <= 4) begin
                chk(push_req && push_sel == 2'(k - 1), {tag, " R2 push order"}, push_sel, k - 1);
                chk(sp_dec == 1'b1, {tag, " R3 sp_dec"}, sp_dec, 1);
                chk(ie_clr == (k == 2), {tag, " R4 ie_clr"}, ie_clr, (k == 2));
            end else begin
                chk(pc_load && !push_req && !sp_dec, {tag, " R2 R3 vector cycle"}, {pc_load, push_req, sp_dec}, 3'b100);
                chk(vec_addr == 16'hFFFF, {tag, " R2 vector"}, vec_addr, 16'hFFFF);
            end
            if (k == 1) chk(cause_word == exp_cause, {tag, " R9 cause"}, cause_word, exp_cause);
        end
        @(negedge clk);
        chk(busy == 1'b0, {tag, " R2 end"}, busy, 0);
    endtask

    // Take any leftover pending sources.
    task automatic drain();
        irq_en = 1'b1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk) insn_bound = 1'b1;
            @(negedge clk) insn_bound = 1'b0;
            if (busy) repeat (4) @(negedge clk);
        end
    endtask

    task automatic post(input logic [7:0] irq, input logic nmi, input logic brk, input logic en);
        @(negedge clk);
        irq_req = irq; brk_exec = brk; irq_en = en;
        if (nmi) nmi_n = 1'b0;
        @(negedge clk);
        irq_req = '0; brk_exec = 1'b0; nmi_n = 1'b1;
    endtask

    task automatic expect_idle_boundary(input string tag);
        @(negedge clk) insn_bound = 1'b1;
        @(negedge clk) insn_bound = 1'b0;
        chk(busy == 1'b0, tag, busy, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!busy && !push_req && !sp_dec && !ie_clr && !pc_load, "R1 strobes",
            {busy, push_req, sp_dec, ie_clr, pc_load}, 0);
        chk(cause_word == 6'd0, "R1 cause", cause_word, 0);
        @(negedge clk) rst_n = 1'b1;

        // Vector table: R6 R7 R8 R9 R11 patterns
        for (int v = 0; v < NV; v++) begin
            post(VTAB[v][16:9], VTAB[v][8], VTAB[v][7], VTAB[v][6]);
            run_entry(VTAB[v][5:0], $sformatf("vec%0d R6 R8", v));
            drain();
            irq_en = 1'b0;
        end

        // R8 loser taken later: NMI + IRQ 3, enable low then high
        post(8'b0000_1000, 1'b1, 1'b0, 1'b0);
        run_entry(6'b010_000, "R8 nmi first");
        expect_idle_boundary("R5 masked irq not taken");
        irq_en = 1'b1;
        run_entry(6'b001_011, "R8 irq after enable");
        expect_idle_boundary("R5 latch cleared after take");

        // R6 remaining levels in order
        post(8'b0101_0000, 1'b0, 1'b0, 1'b1);
        run_entry(6'b001_100, "R6 level4");
        run_entry(6'b001_110, "R6 level6");
        expect_idle_boundary("R6 none left");

        // R7 NMI held low gives one entry, enable ignored
        irq_en = 1'b0;
        @(negedge clk) nmi_n = 1'b0;
        run_entry(6'b010_000, "R7 nmi held");
        expect_idle_boundary("R7 no retrigger");
        @(negedge clk) nmi_n = 1'b1;

        // R10 boundary held through entry
        post(8'b0001_0100, 1'b0, 1'b0, 1'b1);
        @(negedge clk) insn_bound = 1'b1;
        for (int k = 1; k <= 5; k++) begin
            @(negedge clk);
            if (k == 5) chk(pc_load == 1'b1, "R10 vector on time", pc_load, 1);
        end
        @(negedge clk);
        chk(busy == 1'b0 && cause_word == 6'b001_010, "R10 idle gap", {busy, cause_word}, 7'b0_001010);
        @(negedge clk) insn_bound = 1'b0;
        chk(busy && push_sel == 2'd0 && cause_word == 6'b001_100, "R10 second entry",
            {busy, cause_word}, 7'b1_001100);
        repeat (5) @(negedge clk);
        drain();

        // R11 breakpoint with enable low
        irq_en = 1'b0;
        post(8'h00, 1'b0, 1'b1, 1'b0);
        run_entry(6'b100_000, "R11 brk masked");
        expect_idle_boundary("R11 no repeat");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule